// File: doc/BRIEF.md
# Dual-Channel IDE Card Register Decode and Interrupt Logic

This block is the host-side register decoder of an expansion card that carries two IDE channels. The host reaches it over a byte-wide register bus: a 14-bit address, a read strobe, a write strobe, write data, and read data that is registered. The block decodes the taskfile and control windows of both channels into drive chip selects and a register index. It keeps an interrupt enable for each channel. Reading a channel's interrupt-control location clears that enable, and writing the location sets it. Each channel has a status byte that shows whether the channel's drive interrupt line is raised, and one card interrupt output combines the enabled channels.

A select register at address 0 does two jobs. It routes the single DMA request and acknowledge path to one of the two channels. It also opens the taskfile window. While the window is closed, taskfile and control addresses return a fixed ROM placeholder byte and raise no drive chip select, so firmware can read the card ROM after a soft reboot. A 4-bit card type code is spread over the low bits of four identification bytes.

The host bus is a plain register interface with single-cycle strobes and no back-pressure. Each strobe that is high at a rising clock edge is one access. Read data appears on the edge that takes the read and holds until the next read.

Top module: `ide_dual_bus`

## Requirements
- R1: While reset is held, and right after it ends, the select register and both interrupt enables are 0, `bus_rdata` is 0, `card_irq` is low and no drive chip select is active.
- R2: A write of any value to 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's interrupt enable.
- R3: A read of 0x2200 or 0x3200 clears that channel's enable and returns 0. If a read and a write hit the same location in one cycle, the write wins.
- R4: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns the channel's drive interrupt level in bit 0 and zeros in bits 7:1, whatever the enable.
- R5: `card_irq` is high exactly when some channel has its enable set and its drive interrupt input high. The output follows the inputs with no register in between.
- R6: Address 0x0000 holds an 8-bit select register that reads back its value. Bit 0 routes DMA: `dma_req` equals `drv_dmarq[bit0]`, and `dma_ack` reaches only `drv_dmack[bit0]`.
- R7: While select bit 5 is 1, an access to 0x2000+(n<<6) or 0x3000+(n<<6), with n from 0 to 7, raises `drv_cs_tf` for channel 0 or 1 respectively and puts n on `drv_reg`. An access to 0x2380 or 0x3380 raises `drv_cs_ctl` for that channel. `drv_rd` and `drv_wr` follow the strobe, and a read returns `drv_rdata` as sampled at the read edge.
- R8: While select bit 5 is 0, taskfile and control addresses raise no chip select or drive strobe, and reads there return ROM_FILL (default 0xFF).
- R9: A read of 0x2280+4k, with k from 0 to 3, returns bit k of CARD_TYPE (default 3) in bit 0 and zeros elsewhere, with the window open or closed.
- R10: Any other address reads 0, and a write to it changes neither the select register nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Host register address |
| bus_rd | input | 1 | Host read strobe, one access per high cycle |
| bus_wr | input | 1 | Host write strobe, one access per high cycle |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data, updated on a read edge |
| drv_irq | input | 2 | Drive interrupt level, one bit per channel |
| drv_rdata | input | 8 | Data returned by the selected drive register |
| drv_cs_tf | output | 2 | Taskfile chip select per channel |
| drv_cs_ctl | output | 2 | Control/alternate-status chip select per channel |
| drv_reg | output | 3 | Taskfile register index |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_wdata | output | 8 | Data passed to the drive |
| drv_dmarq | input | 2 | DMA request per channel |
| dma_req | output | 1 | DMA request to the single DMA engine |
| dma_ack | input | 1 | DMA acknowledge from the engine |
| drv_dmack | output | 2 | DMA acknowledge routed to one channel |
| card_irq | output | 1 | Combined card interrupt |

## Verification
Chip selects, `drv_reg`, the drive strobes, the DMA routing and `card_irq` depend only on the address, the strobes and the present state. The bench checks them one nanosecond after it drives the inputs, in the same cycle. Read data, enable changes and select changes take effect at the edge that takes the access. The bench updates its model at that edge and checks `bus_rdata`, and then `card_irq` again, one nanosecond later. Expected read data comes from the model state and drive inputs as they stood before the edge.

// File: rtl/ide_dual_pkg.sv
package ide_dual_pkg;
  localparam int BUS_AW   = 14;
  localparam int DATA_W   = 8;
  localparam int N_CH     = 2;
  localparam int CH_W     = 1;
  localparam int IDX_W    = 3;
  localparam int TF_SHIFT = 6;
  localparam int OFF_W    = 12;
  localparam int TF_TOP   = TF_SHIFT + IDX_W;

  localparam logic [OFF_W-1:0] OFF_IRQC  = 12'h200;
  localparam logic [OFF_W-1:0] OFF_STAT  = 12'h290;
  localparam logic [OFF_W-1:0] OFF_CTL   = 12'h380;
  localparam logic [7:0]       IDENT_ROW = 8'h28;

  localparam int SEL_ROUTE_BIT = 0;
  localparam int SEL_OPEN_BIT  = 5;

  typedef enum logic [2:0] {
    HIT_NONE, HIT_SEL, HIT_TF, HIT_CTL, HIT_IRQC, HIT_STAT, HIT_IDENT
  } hit_e;

  typedef struct packed {
    hit_e             kind;
    logic [CH_W-1:0]  ch;
    logic [IDX_W-1:0] idx;
  } hit_t;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_dual_pkg::*;
(
  input  logic [BUS_AW-1:0] addr_i,
  output hit_t              hit_o
);
  logic [OFF_W-1:0] off;
  logic [1:0]       win;

  assign off = addr_i[OFF_W-1:0];
  assign win = addr_i[BUS_AW-1:OFF_W];

  always_comb begin
    hit_o.kind = HIT_NONE;
    hit_o.ch   = '0;
    hit_o.idx  = '0;
    if (addr_i == '0) begin
      hit_o.kind = HIT_SEL;
    end else if (win[1]) begin
      hit_o.ch = win[0];
      if (off[OFF_W-1:TF_TOP] == '0 && off[TF_SHIFT-1:0] == '0) begin
        hit_o.kind = HIT_TF;
        hit_o.idx  = off[TF_TOP-1:TF_SHIFT];
      end else if (off == OFF_CTL) begin
        hit_o.kind = HIT_CTL;
      end else if (off == OFF_IRQC) begin
        hit_o.kind = HIT_IRQC;
      end else if (off == OFF_STAT) begin
        hit_o.kind = HIT_STAT;
      end else if (!win[0] && off[OFF_W-1:4] == IDENT_ROW && off[1:0] == 2'b00) begin
        hit_o.kind = HIT_IDENT;
        hit_o.idx  = {1'b0, off[3:2]};
      end
    end
  end
endmodule

// File: rtl/ide_irq_chan.sv
module ide_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_i,
  output logic en_o,
  output logic req_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
    else if (clr_i) en_o <= 1'b0;
  end

  assign req_o = en_o & irq_i;
endmodule

// File: rtl/ide_dma_route.sv
module ide_dma_route
  import ide_dual_pkg::*;
(
  input  logic [CH_W-1:0] route_i,
  input  logic [N_CH-1:0] drv_dmarq_i,
  input  logic            dma_ack_i,
  output logic            dma_req_o,
  output logic [N_CH-1:0] drv_dmack_o
);
  assign dma_req_o = drv_dmarq_i[route_i];

  for (genvar c = 0; c < N_CH; c++) begin : g_ack
    assign drv_dmack_o[c] = dma_ack_i && (route_i == CH_W'(c));
  end
endmodule

// File: rtl/ide_read_mux.sv
module ide_read_mux
  import ide_dual_pkg::*;
#(
  parameter logic [3:0]        CARD_TYPE = 4'd3,
  parameter logic [DATA_W-1:0] ROM_FILL  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  hit_t              hit_i,
  input  logic [DATA_W-1:0] sel_i,
  input  logic              open_i,
  input  logic [DATA_W-1:0] drv_rdata_i,
  input  logic [N_CH-1:0]   drv_irq_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [(1<<IDX_W)-1:0] TYPE_EXT = {{((1<<IDX_W)-4){1'b0}}, CARD_TYPE};

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    unique case (hit_i.kind)
      HIT_SEL:          nxt = sel_i;
      HIT_TF, HIT_CTL:  nxt = open_i ? drv_rdata_i : ROM_FILL;
      HIT_STAT:         nxt = {{(DATA_W-1){1'b0}}, drv_irq_i[hit_i.ch]};
      HIT_IDENT:        nxt = {{(DATA_W-1){1'b0}}, TYPE_EXT[hit_i.idx]};
      default:          nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= nxt;
  end
endmodule

// File: rtl/ide_dual_bus.sv
module ide_dual_bus
  import ide_dual_pkg::*;
#(
  parameter logic [3:0]        CARD_TYPE = 4'd3,
  parameter logic [DATA_W-1:0] ROM_FILL  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CH-1:0]   drv_irq,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic [N_CH-1:0]   drv_cs_tf,
  output logic [N_CH-1:0]   drv_cs_ctl,
  output logic [IDX_W-1:0]  drv_reg,
  output logic              drv_rd,
  output logic              drv_wr,
  output logic [DATA_W-1:0] drv_wdata,
  input  logic [N_CH-1:0]   drv_dmarq,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic [N_CH-1:0]   drv_dmack,
  output logic              card_irq
);
  hit_t              hit;
  logic [DATA_W-1:0] sel_q;
  logic [N_CH-1:0]   irq_en;
  logic [N_CH-1:0]   irq_req;
  logic              tf_open;
  logic              acc;
  logic              drv_hit;

  ide_addr_decode u_dec (.addr_i(bus_addr), .hit_o(hit));

  always_ff @(posedge clk) begin
    if (!rst_n)                          sel_q <= '0;
    else if (bus_wr && hit.kind == HIT_SEL) sel_q <= bus_wdata;
  end

  assign tf_open = sel_q[SEL_OPEN_BIT];
  assign acc     = bus_rd | bus_wr;
  assign drv_hit = tf_open && (hit.kind == HIT_TF || hit.kind == HIT_CTL);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic ch_match;
    assign ch_match = (hit.ch == CH_W'(c));

    ide_irq_chan u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (bus_wr && hit.kind == HIT_IRQC && ch_match),
      .clr_i (bus_rd && hit.kind == HIT_IRQC && ch_match),
      .irq_i (drv_irq[c]),
      .en_o  (irq_en[c]),
      .req_o (irq_req[c])
    );

    assign drv_cs_tf[c]  = acc && tf_open && hit.kind == HIT_TF  && ch_match;
    assign drv_cs_ctl[c] = acc && tf_open && hit.kind == HIT_CTL && ch_match;
  end

  assign card_irq  = |irq_req;
  assign drv_reg   = (acc && tf_open && hit.kind == HIT_TF) ? hit.idx : '0;
  assign drv_rd    = bus_rd && drv_hit;
  assign drv_wr    = bus_wr && drv_hit;
  assign drv_wdata = bus_wdata;

  ide_dma_route u_route (
    .route_i     (sel_q[SEL_ROUTE_BIT]),
    .drv_dmarq_i (drv_dmarq),
    .dma_ack_i   (dma_ack),
    .dma_req_o   (dma_req),
    .drv_dmack_o (drv_dmack)
  );

  ide_read_mux #(.CARD_TYPE(CARD_TYPE), .ROM_FILL(ROM_FILL)) u_rmux (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_i        (bus_rd),
    .hit_i       (hit),
    .sel_i       (sel_q),
    .open_i      (tf_open),
    .drv_rdata_i (drv_rdata),
    .drv_irq_i   (drv_irq),
    .rdata_o     (bus_rdata)
  );
endmodule

// File: rtl/ide_dual_bus_chk.sv
module ide_dual_bus_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [1:0]  drv_irq,
  input logic        card_irq,
  input logic [1:0]  drv_cs_tf,
  input logic [1:0]  drv_cs_ctl,
  input logic [1:0]  irq_en,
  input logic [1:0]  drv_dmack,
  input logic        dma_ack,
  input logic        sel_open,
  input logic        sel_route
);
  a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 14'h2200) |=> irq_en[0]);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 14'h3200) |=> !irq_en[1]);

  a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq |-> (drv_irq != 2'b00));

  a_r8_closed_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_open |-> (drv_cs_tf == 2'b00 && drv_cs_ctl == 2'b00));

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_cs_tf, drv_cs_ctl}));

  a_r6_ack_route: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_dmack[1] |-> sel_route) and (drv_dmack[0] |-> !sel_route));

  a_r6_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_dmack != 2'b00) |-> dma_ack);
endmodule

bind ide_dual_bus ide_dual_bus_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .drv_irq    (drv_irq),
  .card_irq   (card_irq),
  .drv_cs_tf  (drv_cs_tf),
  .drv_cs_ctl (drv_cs_ctl),
  .irq_en     (irq_en),
  .drv_dmack  (drv_dmack),
  .dma_ack    (dma_ack),
  .sel_open   (sel_q[5]),
  .sel_route  (sel_q[0])
);

// File: tb/ide_dual_bus_test.sv
module ide_dual_bus_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic [7:0]  drv_rdata = '0;
  logic [1:0]  drv_cs_tf, drv_cs_ctl, drv_dmack;
  logic [2:0]  drv_reg;
  logic        drv_rd, drv_wr, dma_req, card_irq;
  logic [7:0]  drv_wdata;
  logic [1:0]  drv_dmarq = '0;
  logic        dma_ack = 1'b0;

  int errs = 0, checks = 0;
  logic [7:0] sel_m = '0;
  logic [1:0] en_m = '0;
  bit rand_pins = 1'b1;

  localparam logic [3:0] TYPE_EXP = 4'd3;
  localparam logic [7:0] FILL_EXP = 8'hFF;

  always #4 clk = ~clk;

  ide_dual_bus uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kinds: 0 none, 1 select, 2 taskfile, 3 control, 4 irq control, 5 status, 6 ident
  function automatic void classify(input logic [13:0] a, output int kind,
                                   output int ch, output int idx);
    logic [11:0] off = a[11:0];
    kind = 0; ch = 0; idx = 0;
    if (a == 14'h0) kind = 1;
    else if (a[13]) begin
      ch = a[12];
      if (off[11:9] == 0 && off[5:0] == 0) begin kind = 2; idx = off[8:6]; end
      else if (off == 12'h380) kind = 3;
      else if (off == 12'h200) kind = 4;
      else if (off == 12'h290) kind = 5;
      else if (ch == 0 && (off == 12'h280 || off == 12'h284 || off == 12'h288 || off == 12'h28C)) begin
        kind = 6; idx = off[3:2];
      end
    end
  endfunction

  function automatic logic [7:0] exp_rdata(input int kind, input int ch, input int idx);
    case (kind)
      1: return sel_m;
      2, 3: return sel_m[5] ? drv_rdata : FILL_EXP;
      5: return {7'b0, drv_irq[ch]};
      6: return {7'b0, TYPE_EXP[idx]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_req(input int kind);
    case (kind)
      1: return "R6";
      2, 3: return sel_m[5] ? "R7" : "R8";
      4: return "R3";
      5: return "R4";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic bus_access(input bit rd, input bit wr, input logic [13:0] a,
                            input logic [7:0] wd);
    int kind, ch, idx;
    logic [1:0] ecs_tf, ecs_ctl, edmack;
    logic [2:0] ereg;
    logic [7:0] erd;
    bit eirq, open;
    string rq;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    if (rand_pins) begin
      drv_irq = 2'($urandom); drv_rdata = 8'($urandom);
      drv_dmarq = 2'($urandom); dma_ack = 1'($urandom);
    end
    #1;
    classify(a, kind, ch, idx);
    open = sel_m[5];
    ecs_tf  = ((rd | wr) && open && kind == 2) ? 2'(1 << ch) : 2'b00;
    ecs_ctl = ((rd | wr) && open && kind == 3) ? 2'(1 << ch) : 2'b00;
    ereg    = ((rd | wr) && open && kind == 2) ? 3'(idx) : 3'd0;
    rq = open ? "R7" : "R8";
    chk({drv_cs_tf, drv_cs_ctl} == {ecs_tf, ecs_ctl}, rq, "chip selects",
        {drv_cs_tf, drv_cs_ctl}, {ecs_tf, ecs_ctl});
    chk(drv_reg == ereg, rq, "register index", drv_reg, ereg);
    chk({drv_rd, drv_wr} == {rd && open && (kind == 2 || kind == 3), wr && open && (kind == 2 || kind == 3)},
        rq, "drive strobes", {drv_rd, drv_wr},
        {rd && open && (kind == 2 || kind == 3), wr && open && (kind == 2 || kind == 3)});
    edmack = dma_ack ? (sel_m[0] ? 2'b10 : 2'b01) : 2'b00;
    chk(dma_req == drv_dmarq[sel_m[0]] && drv_dmack == edmack, "R6", "dma routing",
        {dma_req, drv_dmack}, {drv_dmarq[sel_m[0]], edmack});
    eirq = |(en_m & drv_irq);
    chk(card_irq == eirq, "R5", "card_irq before edge", card_irq, eirq);
    erd = exp_rdata(kind, ch, idx);
    @(posedge clk);
    if (wr && kind == 1) sel_m = wd;
    if (kind == 4) begin
      if (wr) en_m[ch] = 1'b1;
      else if (rd) en_m[ch] = 1'b0;
    end
    #1;
    if (rd) chk(bus_rdata == erd, wr ? "R3" : rd_req(kind), "read data", bus_rdata, erd);
    eirq = |(en_m & drv_irq);
    chk(card_irq == eirq, (kind == 4) ? (wr ? "R2" : "R3") : "R5", "card_irq after edge",
        card_irq, eirq);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  function automatic logic [13:0] pick_addr();
    case ($urandom % 20)
      0: return 14'h0000;   1: return 14'h2200;  2: return 14'h3200;
      3: return 14'h2290;   4: return 14'h3290;  5: return 14'h2000;
      6: return 14'h21C0;   7: return 14'h2080;  8: return 14'h3040;
      9: return 14'h3380;  10: return 14'h2380; 11: return 14'h2280;
      12: return 14'h2284; 13: return 14'h2288; 14: return 14'h228C;
      15: return 14'h2201; 16: return 14'h3280;
      default: return 14'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state with drive interrupts raised
    drv_irq = 2'b11;
    repeat (4) @(posedge clk);
    #1;
    chk(card_irq == 1'b0, "R1", "card_irq in reset", card_irq, 0);
    chk(bus_rdata == 8'h00, "R1", "rdata in reset", bus_rdata, 0);
    chk({drv_cs_tf, drv_cs_ctl} == 4'b0, "R1", "selects in reset", {drv_cs_tf, drv_cs_ctl}, 0);
    @(negedge clk); rst_n = 1'b1;
    rand_pins = 1'b0;
    bus_access(1, 0, 14'h0000, 8'h00);                // R1 select reads 0
    chk(bus_rdata == 8'h00, "R1", "select after reset", bus_rdata, 0);
    bus_access(0, 1, 14'h2200, 8'h00);                // R2 enable channel 0
    bus_access(0, 1, 14'h3200, 8'h5A);                // R2 enable channel 1
    bus_access(1, 0, 14'h2290, 8'h00);                // R4 status
    drv_irq = 2'b10;
    bus_access(1, 0, 14'h2200, 8'h00);                // R3 disable ch0
    bus_access(1, 1, 14'h3200, 8'h00);                // R3 write wins
    chk(card_irq == 1'b1, "R3", "write wins on collision", card_irq, 1);
    bus_access(1, 0, 14'h3200, 8'h00);                // R3 disable ch1
    chk(card_irq == 1'b0, "R5", "irq masked after disable", card_irq, 0);
    bus_access(1, 0, 14'h3290, 8'h00);                // R4 status while disabled
    chk(bus_rdata == 8'h01, "R4", "status ignores enable", bus_rdata, 1);
    bus_access(1, 0, 14'h2040, 8'h00);                // R8 closed window
    chk(bus_rdata == FILL_EXP, "R8", "ROM fill", bus_rdata, FILL_EXP);
    for (int k = 0; k < 4; k++) bus_access(1, 0, 14'(14'h2280 + 4 * k), 8'h00);  // R9
    bus_access(0, 1, 14'h0000, 8'h21);                // R6/R7 open, route ch1
    drv_rdata = 8'hC3;
    bus_access(1, 0, 14'h31C0, 8'h00);                // R7 ch1 reg 7
    chk(bus_rdata == 8'hC3, "R7", "taskfile read data", bus_rdata, 8'hC3);
    bus_access(0, 1, 14'h2380, 8'h77);                // R7 control write
    bus_access(0, 1, 14'h2201 , 8'hFF);               // R10 unmapped write
    bus_access(1, 0, 14'h0000, 8'h00);
    chk(bus_rdata == 8'h21, "R10", "select unchanged by unmapped write", bus_rdata, 8'h21);
    bus_access(0, 1, 14'h0000, 8'h00);                // R8 close again
    bus_access(0, 1, 14'h3000, 8'h11);                // R8 no cs
    rand_pins = 1'b1;
    for (int i = 0; i < 600; i++) begin
      bit r = 1'($urandom);
      bus_access(r, !r, pick_addr(), 8'($urandom));
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule